// File: doc/BRIEF.md
# Fault-Configuration Frame Receiver

This block sits behind a UART receiver and turns a stream of received bytes into one complete configuration frame for a set of fault-injection units. It takes one byte at a time, together with the receiver's framing-error flag. The frame length is fixed and follows from two parameters: the number of units and the timer width. A frame starts with the packed fault patterns of all units. Next come two timer load values, a control byte, a 16-bit design identifier and a one-byte CRC. When the last byte arrives, the block presents the parsed fields and three error flags for one cycle, marked by a done strobe. The fields then stay unchanged until the next frame completes.

Errors never shorten a frame. The block always takes in exactly the expected number of bytes, so the frame boundary stays aligned with the sender, and it only reports what went wrong once the frame is over. The consumer then decides whether to act on the fields.

The control path is a state machine with six states. It always walks them in one fixed order:

- ST_PAT collects the pattern bytes and moves on to ST_T1 after its last pattern byte.
- ST_T1 collects the first timer and moves on to ST_T2.
- ST_T2 collects the second timer and moves on to ST_CTRL.
- ST_CTRL takes the single control byte and moves on to ST_ID.
- ST_ID takes two identifier bytes and moves on to ST_CRC.
- ST_CRC takes the check byte, raises done and returns to ST_PAT.

Within a state, a byte counter advances on each accepted byte. The state changes when the counter reaches that state's byte count. Cycles without a valid byte change nothing.

Top module: `cfg_frame_rx`

## Requirements
- R1: A frame is exactly PAT_BYTES + 2*TMR_BYTES + 4 accepted bytes, where PAT_BYTES = ceil(6*NUM_UNITS/8) and TMR_BYTES = ceil(TMR_W/8). done_o rises in the cycle after the clock edge that accepts the final byte, and at no other time. NUM_UNITS must be at least 2.
- R2: The pattern bytes, read as one little-endian number V (byte 0 least significant), carry STUFF = 8*PAT_BYTES - 6*NUM_UNITS ignored padding bits at V[STUFF-1:0]. Unit u then takes V[STUFF+6*(NUM_UNITS-1-u) +: 6]. The low 3 bits of that slice are pattern 1, which appears on pat1_o[3u+2:3u]. The high 3 bits are pattern 2, which appears on pat2_o[3u+2:3u].
- R3: Each timer is TMR_BYTES bytes, least significant byte first. Its low TMR_W bits appear on t1_o / t2_o, and the bits above TMR_W are discarded.
- R4: The control byte appears unchanged on ctrl_o. The identifier is two bytes, low byte first. err_id_o is 1 exactly when the identifier differs from ID_VALUE.
- R5: The check value starts at 0xFF and is updated over every byte before the check byte. Each update XORs in the byte and then performs 8 right shifts; after each shift the value is XORed with 0xE0 when the bit shifted out was 1. err_crc_o is 1 exactly when the result differs from the received check byte.
- R6: err_uart_o is 1 when rx_ferr_i was high on any accepted byte of the frame, the check byte included. The flag is cleared for the next frame.
- R7: Framing, identifier and check errors do not end a frame early. The following frame is parsed from its own first byte.
- R8: done_o is high for exactly one cycle per frame.
- R9: Between two done pulses, pat1_o, pat2_o, t1_o, t2_o, ctrl_o and the three error flags hold their values.
- R10: After reset, done_o, all fields and all error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid_i | input | 1 | A received byte is present this cycle |
| rx_data_i | input | 8 | Received byte |
| rx_ferr_i | input | 1 | Framing error on the byte presented this cycle |
| done_o | output | 1 | One-cycle strobe: frame complete, fields valid |
| pat1_o | output | 3*NUM_UNITS | First fault pattern of each unit, unit u at bits 3u+2:3u |
| pat2_o | output | 3*NUM_UNITS | Second fault pattern of each unit |
| t1_o | output | TMR_W | First timer load value |
| t2_o | output | TMR_W | Second timer load value |
| ctrl_o | output | 8 | Control byte |
| err_uart_o | output | 1 | A framing error occurred in the frame |
| err_id_o | output | 1 | Identifier mismatch |
| err_crc_o | output | 1 | Check byte mismatch |

## Verification
Directed frames come first:

- All-ones patterns with all-ones padding show whether the padding leaks into unit 2's pattern 1.
- Timer values with bits set above TMR_W show whether the discarded top bits are masked.
- A framing error on the first byte, and another on the check byte, tell a sticky flag apart from one that only samples a single byte.
- A clean frame right after an error frame shows whether the flag clears.
- Frames with only a wrong identifier, only a corrupted check byte, or both, show that the error flags are independent and that the frame is never cut short.

Random frames then vary patterns, timers, control bytes and error injection, with random idle gaps between bytes. These show whether the byte counting ignores idle cycles and whether every field holds its value while the next frame is arriving.

// File: rtl/cfg_rx_pkg.sv
package cfg_rx_pkg;

    typedef enum logic [2:0] {
        ST_PAT,
        ST_T1,
        ST_T2,
        ST_CTRL,
        ST_ID,
        ST_CRC
    } rx_state_e;

    localparam logic [7:0] CRC_POLY_REFL = 8'hE0;
    localparam logic [7:0] CRC_SEED      = 8'hFF;

    // one byte of the reflected check value update
    function automatic logic [7:0] crc8_step(logic [7:0] cur, logic [7:0] din);
        logic [7:0] x;
        x = cur ^ din;
        for (int i = 0; i < 8; i++) begin
            x = x[0] ? ((x >> 1) ^ CRC_POLY_REFL) : (x >> 1);
        end
        return x;
    endfunction

endpackage

// File: rtl/cfg_rx_crc8.sv
module cfg_rx_crc8
    import cfg_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear_i,
    input  logic       en_i,
    input  logic [7:0] data_i,
    output logic [7:0] crc_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_o <= CRC_SEED;
        end else if (clear_i) begin
            crc_o <= CRC_SEED;
        end else if (en_i) begin
            crc_o <= crc8_step(crc_o, data_i);
        end
    end

    AST_CRC_RESEED: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (crc_o == CRC_SEED)); // R5

endmodule

// File: rtl/cfg_rx_unpack.sv
module cfg_rx_unpack #(
    parameter int NUM_UNITS = 3,
    parameter int PAT_BITS  = 6 * NUM_UNITS
) (
    input  logic [PAT_BITS-1:0]    pat_i,
    output logic [3*NUM_UNITS-1:0] pat1_o,
    output logic [3*NUM_UNITS-1:0] pat2_o
);

    // the highest unit index sits lowest in the stream
    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        localparam int BASE = 6 * (NUM_UNITS - 1 - u);
        assign pat1_o[3*u +: 3] = pat_i[BASE +: 3];
        assign pat2_o[3*u +: 3] = pat_i[BASE + 3 +: 3];
    end

endmodule

// File: rtl/cfg_frame_rx.sv
module cfg_frame_rx
    import cfg_rx_pkg::*;
#(
    parameter int          NUM_UNITS = 3,
    parameter int          TMR_W     = 12,
    parameter logic [15:0] ID_VALUE  = 16'hA5C3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rx_valid_i,
    input  logic [7:0]             rx_data_i,
    input  logic                   rx_ferr_i,
    output logic                   done_o,
    output logic [3*NUM_UNITS-1:0] pat1_o,
    output logic [3*NUM_UNITS-1:0] pat2_o,
    output logic [TMR_W-1:0]       t1_o,
    output logic [TMR_W-1:0]       t2_o,
    output logic [7:0]             ctrl_o,
    output logic                   err_uart_o,
    output logic                   err_id_o,
    output logic                   err_crc_o
);

    localparam int PAT_BITS  = 6 * NUM_UNITS;
    localparam int PAT_BYTES = (PAT_BITS + 7) / 8;
    localparam int TMR_BYTES = (TMR_W + 7) / 8;
    localparam int MAX_LEN   = (PAT_BYTES > TMR_BYTES) ?
                               ((PAT_BYTES > 2) ? PAT_BYTES : 2) :
                               ((TMR_BYTES > 2) ? TMR_BYTES : 2);
    localparam int CNT_W     = $clog2(MAX_LEN + 1);

    function automatic int state_len(rx_state_e s);
        int n;
        unique case (s)
            ST_PAT:  n = PAT_BYTES;
            ST_T1:   n = TMR_BYTES;
            ST_T2:   n = TMR_BYTES;
            ST_CTRL: n = 1;
            ST_ID:   n = 2;
            default: n = 1;
        endcase
        return n;
    endfunction

    rx_state_e          state_q, state_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic               last_byte;
    logic               frame_end;

    logic [PAT_BITS-1:0] pat_sr, pat_pub;
    logic [TMR_W-1:0]    t1_sr, t2_sr;
    logic [7:0]          ctrl_sr;
    logic [15:0]         id_sr;
    logic                ferr_sticky;
    logic [7:0]          crc_cur;

    assign last_byte = (int'(cnt_q) == state_len(state_q) - 1);
    assign frame_end = rx_valid_i && (state_q == ST_CRC);

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (rx_valid_i) begin
            if (last_byte) begin
                cnt_d = '0;
                unique case (state_q)
                    ST_PAT:  state_d = ST_T1;
                    ST_T1:   state_d = ST_T2;
                    ST_T2:   state_d = ST_CTRL;
                    ST_CTRL: state_d = ST_ID;
                    ST_ID:   state_d = ST_CRC;
                    ST_CRC:  state_d = ST_PAT;
                endcase
            end else begin
                cnt_d = cnt_q + CNT_W'(1);
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PAT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // field capture and publication
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pat_sr      <= '0;
            t1_sr       <= '0;
            t2_sr       <= '0;
            ctrl_sr     <= '0;
            id_sr       <= '0;
            ferr_sticky <= 1'b0;
            done_o      <= 1'b0;
            pat_pub     <= '0;
            t1_o        <= '0;
            t2_o        <= '0;
            ctrl_o      <= '0;
            err_uart_o  <= 1'b0;
            err_id_o    <= 1'b0;
            err_crc_o   <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (rx_valid_i) begin
                ferr_sticky <= frame_end ? 1'b0 : (ferr_sticky | rx_ferr_i);
                unique case (state_q)
                    ST_PAT: pat_sr <= {rx_data_i, pat_sr[PAT_BITS-1:8]};
                    ST_T1: begin
                        for (int k = 0; k < TMR_W; k++) begin
                            if (k / 8 == int'(cnt_q)) t1_sr[k] <= rx_data_i[k % 8];
                        end
                    end
                    ST_T2: begin
                        for (int k = 0; k < TMR_W; k++) begin
                            if (k / 8 == int'(cnt_q)) t2_sr[k] <= rx_data_i[k % 8];
                        end
                    end
                    ST_CTRL: ctrl_sr <= rx_data_i;
                    ST_ID: begin
                        if (cnt_q == '0) id_sr[7:0]  <= rx_data_i;
                        else             id_sr[15:8] <= rx_data_i;
                    end
                    ST_CRC: begin
                        done_o     <= 1'b1;
                        pat_pub    <= pat_sr;
                        t1_o       <= t1_sr;
                        t2_o       <= t2_sr;
                        ctrl_o     <= ctrl_sr;
                        err_uart_o <= ferr_sticky | rx_ferr_i;
                        err_id_o   <= (id_sr != ID_VALUE);
                        err_crc_o  <= (crc_cur != rx_data_i);
                    end
                endcase
            end
        end
    end

    cfg_rx_crc8 i_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (frame_end),
        .en_i    (rx_valid_i && (state_q != ST_CRC)),
        .data_i  (rx_data_i),
        .crc_o   (crc_cur)
    );

    cfg_rx_unpack #(
        .NUM_UNITS (NUM_UNITS),
        .PAT_BITS  (PAT_BITS)
    ) i_unpack (
        .pat_i  (pat_pub),
        .pat1_o (pat1_o),
        .pat2_o (pat2_o)
    );

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) < state_len(state_q)); // R1

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(rx_valid_i) && ($past(state_q) == ST_CRC) && (state_q == ST_PAT))); // R1

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8

    AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(pat_pub) && $stable(t1_o) && $stable(t2_o) && $stable(ctrl_o)
                     && $stable(err_uart_o) && $stable(err_id_o) && $stable(err_crc_o))); // R9

    AST_FERR_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && $past(rx_ferr_i)) |-> err_uart_o); // R6

endmodule

// File: tb/test_cfg_frame_rx.sv
module test_cfg_frame_rx;

    localparam int          NU    = 3;
    localparam int          TW    = 12;
    localparam logic [15:0] IDV   = 16'hA5C3;
    localparam int          PB    = (6 * NU + 7) / 8;
    localparam int          TB    = (TW + 7) / 8;
    localparam int          STUFF = 8 * PB - 6 * NU;
    localparam int          FB    = PB + 2 * TB + 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic rx_ferr = 1'b0;
    logic done;
    logic [3*NU-1:0] pat1, pat2;
    logic [TW-1:0] t1, t2;
    logic [7:0] ctrl;
    logic e_uart, e_id, e_crc;

    always #4 clk = ~clk;

    cfg_frame_rx #(.NUM_UNITS(NU), .TMR_W(TW), .ID_VALUE(IDV)) i_cfg_frame_rx (
        .clk(clk), .rst_n(rst_n), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
        .rx_ferr_i(rx_ferr), .done_o(done), .pat1_o(pat1), .pat2_o(pat2),
        .t1_o(t1), .t2_o(t2), .ctrl_o(ctrl), .err_uart_o(e_uart),
        .err_id_o(e_id), .err_crc_o(e_crc)
    );

    int total = 0;
    int bad = 0;
    logic [7:0] fb [FB];

    logic [3*NU-1:0] x_p1, x_p2;
    logic [TW-1:0]   x_t1, x_t2;
    logic [7:0]      x_ctrl;
    logic [2:0]      x_err;
    logic            have_prev = 1'b0;

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_crc(int n);
        logic [7:0] c;
        c = 8'hFF;
        for (int i = 0; i < n; i++) begin
            c = c ^ fb[i];
            for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 8'hE0) : (c >> 1);
        end
        return c;
    endfunction

    task automatic build(logic [3*NU-1:0] p1, logic [3*NU-1:0] p2, logic [7:0] stuff,
                         logic [8*TB-1:0] tv1, logic [8*TB-1:0] tv2, logic [7:0] cb,
                         logic [15:0] id, logic crc_bad);
        logic [8*PB-1:0] v;
        v = '0;
        v[7:0] = stuff;
        for (int u = 0; u < NU; u++) begin
            v[STUFF + 6*(NU-1-u) +: 6] = {p2[3*u +: 3], p1[3*u +: 3]};
        end
        for (int j = 0; j < PB; j++) fb[j] = v[8*j +: 8];
        for (int j = 0; j < TB; j++) begin
            fb[PB + j]      = tv1[8*j +: 8];
            fb[PB + TB + j] = tv2[8*j +: 8];
        end
        fb[PB + 2*TB]     = cb;
        fb[PB + 2*TB + 1] = id[7:0];
        fb[PB + 2*TB + 2] = id[15:8];
        fb[FB-1] = ref_crc(FB - 1) ^ (crc_bad ? 8'h5A : 8'h00);
        x_p1 = p1;
        x_p2 = p2;
        x_t1 = tv1[TW-1:0];
        x_t2 = tv2[TW-1:0];
        x_ctrl = cb;
        x_err[1] = (id != IDV);
        x_err[0] = crc_bad;
    endtask

    // ferr_at < 0: no framing error
    task automatic send(int ferr_at, int gapmax);
        logic early;
        early = 1'b0;
        x_err[2] = (ferr_at >= 0);
        @(negedge clk);
        for (int i = 0; i < FB; i++) begin
            rx_valid = 1'b1;
            rx_data  = fb[i];
            rx_ferr  = (i == ferr_at);
            @(negedge clk);
            rx_valid = 1'b0;
            rx_ferr  = 1'b0;
            if (i == FB - 2 && have_prev) begin
                // R9: old results still visible while this frame is in flight
                check("R9 hold", {pat1, pat2, t1, t2, ctrl, e_uart, e_id, e_crc},
                      {hp1, hp2, ht1, ht2, hctrl, herr});
            end
            if (i != FB - 1) begin
                if (done) early = 1'b1;
                repeat ($urandom_range(0, gapmax)) begin
                    @(negedge clk);
                    if (done) early = 1'b1;
                end
            end
        end
        check("R1/R7 no early done", {63'd0, early}, 64'd0);
        check("R1 done after last byte", {63'd0, done}, 64'd1);
        check("R2 pattern1", {40'd0, pat1}, {40'd0, x_p1});
        check("R2 pattern2", {40'd0, pat2}, {40'd0, x_p2});
        check("R3 timers", {t1, t2}, {x_t1, x_t2});
        check("R4 ctrl", {56'd0, ctrl}, {56'd0, x_ctrl});
        check("R4/R5/R6 errors uart,id,crc", {61'd0, e_uart, e_id, e_crc}, {61'd0, x_err});
        @(negedge clk);
        check("R8 done single cycle", {63'd0, done}, 64'd0);
        hp1 = x_p1; hp2 = x_p2; ht1 = x_t1; ht2 = x_t2; hctrl = x_ctrl; herr = x_err;
        have_prev = 1'b1;
    endtask

    logic [3*NU-1:0] hp1, hp2;
    logic [TW-1:0]   ht1, ht2;
    logic [7:0]      hctrl;
    logic [2:0]      herr;

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check("R10 reset outputs", {pat1, pat2, t1, t2, ctrl, e_uart, e_id, e_crc, done}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 idle done", {63'd0, done}, 64'd0);

        // padding all ones must not leak; timer top bits discarded (R2, R3)
        build('1, '1, 8'hFF, 16'hFFFF, 16'hF123, 8'h81, IDV, 1'b0);
        send(-1, 0);
        // distinct per-unit values
        build(9'o765, 9'o012, 8'h00, 16'h0ABC, 16'h0001, 8'h07, IDV, 1'b0);
        send(-1, 2);
        // framing error on first byte, then clean frame clears (R6, R7)
        build(9'o124, 9'o356, 8'h2A, 16'h0F00, 16'h00F0, 8'h3C, IDV, 1'b0);
        send(0, 1);
        build(9'o000, 9'o777, 8'h15, 16'h0123, 16'h0456, 8'h00, IDV, 1'b0);
        send(-1, 0);
        // framing error on the check byte (R6)
        build(9'o333, 9'o444, 8'h00, 16'h0555, 16'h0AAA, 8'hFF, IDV, 1'b0);
        send(FB - 1, 0);
        // identifier mismatch only (R4)
        build(9'o101, 9'o202, 8'h00, 16'h0010, 16'h0020, 8'h11, IDV ^ 16'h0100, 1'b0);
        send(-1, 1);
        // check byte mismatch only (R5)
        build(9'o545, 9'o232, 8'h00, 16'h0777, 16'h0888, 8'h22, IDV, 1'b1);
        send(-1, 0);
        // all three errors at once, frame still full length (R7)
        build(9'o666, 9'o111, 8'h00, 16'h0999, 16'h0333, 8'h44, 16'h0000, 1'b1);
        send(3, 1);

        for (int n = 0; n < 30; n++) begin
            logic [15:0] idr;
            int fa;
            idr = ($urandom_range(0, 3) == 0) ? 16'($urandom) : IDV;
            fa  = ($urandom_range(0, 4) == 0) ? $urandom_range(0, FB - 1) : -1;
            build(9'($urandom), 9'($urandom), 8'($urandom), 16'($urandom), 16'($urandom),
                  8'($urandom), idr, ($urandom_range(0, 4) == 0));
            send(fa, 3);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule